// File: doc/BRIEF.md
# Predicated Vector Last-Element Extractor

This block picks a single element out of a wide vector operand under the control of a byte-granular predicate. The caller supplies the vector, a predicate with one bit per vector byte, a 2-bit element-size code, a mode bit and a valid strobe. The block works out which elements are active at that element size and finds the highest-numbered active one. It then applies one of two selection rules and returns the chosen element, zero-extended to 64 bits.

In "next" mode the element that follows the last active one is returned, and the index wraps to element zero past the end of the vector. In "last" mode the last active element itself is returned. Each mode has its own fallback for a predicate with no active element. The result and its valid strobe come from a register stage, one clock after the input is accepted.

Top module: `vlx_extract`

## Requirements
- R1: `in_size` sets the element width to 8 << size: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. `out_result` carries the element in its low bits, and every bit above the element width is zero.
- R2: An element counts as active only when the predicate bit of its lowest-numbered byte (bit index × bytes per element) is set. Predicate bits of the other bytes of that element have no effect on the result.
- R3: In next mode (`in_mode` = 0) the selected index is the highest active index plus one.
- R4: In next mode, when the highest active element is the final element (element count − 1), the selected index wraps to element 0.
- R5: In next mode with no active element, element 0 is selected.
- R6: In last mode (`in_mode` = 1) the highest active element itself is selected.
- R7: In last mode with no active element, the highest-numbered element (VLEN / width − 1) is selected.
- R8: A cycle with `in_valid` high produces `out_valid` high on the next clock edge, for exactly one cycle per accepted input. The output shows the operand slice starting at bit index × width.
- R9: A synchronous active-high `rst` clears `out_valid` on the next clock edge.
- R10: While `in_valid` is low, `out_result` keeps its last value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| in_size | input | 2 | Element size code |
| in_mode | input | 1 | 0 = next after last active, 1 = last active |
| in_operand | input | VLEN | Vector operand |
| in_pred | input | VLEN/8 | Predicate, one bit per byte |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Zero-extended selected element |

## Verification
Errors in the search or in the index adjustment show up on the very next `out_result` as an element taken from the wrong position. The operand bytes all differ from one another, so a wrong index cannot produce the expected value by chance. Several cases are aimed at specific faults: predicates set only on non-leading bytes catch a wrong active-bit tap, and predicates with the final element active catch a missing wrap. A stale or leaking valid register shows up as a wrong `out_valid` level one cycle after the stimulus.

// File: rtl/vlx_pkg.sv
package vlx_pkg;

    localparam int unsigned RES_W = 64;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } elem_size_e;

    typedef enum logic {
        PICK_NEXT = 1'b0,
        PICK_LAST = 1'b1
    } pick_mode_e;

    typedef struct packed {
        logic             vld;
        logic [RES_W-1:0] data;
    } res_t;

    // Mask covering the low bits of one element at the given size
    function automatic logic [RES_W-1:0] width_mask(elem_size_e s);
        logic [RES_W-1:0] m;
        case (s)
            SZ_B:    m = 64'h0000_0000_0000_00FF;
            SZ_H:    m = 64'h0000_0000_0000_FFFF;
            SZ_W:    m = 64'h0000_0000_FFFF_FFFF;
            default: m = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vlx_active_map.sv
module vlx_active_map
    import vlx_pkg::*;
#(
    parameter int unsigned VLEN = 256,
    localparam int unsigned NB = VLEN / 8
) (
    input  logic [NB-1:0] pred,
    input  elem_size_e    size,
    output logic [NB-1:0] act
);
    logic [NB-1:0] per_size [4];

    // One map per element size: element i takes the bit of its leading byte
    for (genvar s = 0; s < 4; s++) begin : g_size
        for (genvar i = 0; i < NB; i++) begin : g_elem
            if (i < (NB >> s)) begin : g_live
                assign per_size[s][i] = pred[i << s];
            end else begin : g_dead
                assign per_size[s][i] = 1'b0;
            end
        end
    end

    always_comb begin
        act = per_size[size];
    end
endmodule

// File: rtl/vlx_last_find.sv
module vlx_last_find #(
    parameter int unsigned N = 32,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  act,
    output logic [IW-1:0] last_idx,
    output logic          none
);
    // Scan upward; the highest set bit is the last one written
    always_comb begin
        last_idx = '0;
        none     = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (act[i]) begin
                last_idx = IW'(i);
                none     = 1'b0;
            end
        end
    end
endmodule

// File: rtl/vlx_index_adjust.sv
module vlx_index_adjust
    import vlx_pkg::*;
#(
    parameter int unsigned N = 32,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [IW-1:0] last_idx,
    input  logic          none,
    input  elem_size_e    size,
    input  pick_mode_e    mode,
    output logic [IW-1:0] sel_idx
);
    logic [IW-1:0] top_idx;
    logic [IW-1:0] next_idx;

    always_comb begin
        top_idx  = IW'((N >> size) - 1);
        next_idx = (last_idx == top_idx) ? '0 : last_idx + IW'(1);
        if (mode == PICK_NEXT) begin
            sel_idx = none ? '0 : next_idx;
        end else begin
            sel_idx = none ? top_idx : last_idx;
        end
    end
endmodule

// File: rtl/vlx_elem_mux.sv
module vlx_elem_mux
    import vlx_pkg::*;
#(
    parameter int unsigned VLEN = 256,
    localparam int unsigned NB = VLEN / 8,
    localparam int unsigned IW = $clog2(NB),
    localparam int unsigned BW = $clog2(VLEN)
) (
    input  logic [VLEN-1:0]  operand,
    input  elem_size_e       size,
    input  logic [IW-1:0]    idx,
    output logic [RES_W-1:0] data
);
    logic [BW-1:0]   bit_off;
    logic [VLEN-1:0] shifted;

    always_comb begin
        bit_off = {idx, 3'b000} << size;
        shifted = operand >> bit_off;
        data    = shifted[RES_W-1:0] & width_mask(size);
    end
endmodule

// File: rtl/vlx_extract.sv
module vlx_extract
    import vlx_pkg::*;
#(
    parameter int unsigned VLEN = 256,
    localparam int unsigned NB = VLEN / 8,
    localparam int unsigned IW = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_size,
    input  logic              in_mode,
    input  logic [VLEN-1:0]   in_operand,
    input  logic [NB-1:0]     in_pred,
    output logic              out_valid,
    output logic [RES_W-1:0]  out_result
);
    elem_size_e       size_e;
    pick_mode_e       mode_e;
    logic [NB-1:0]    act;
    logic [IW-1:0]    last_idx;
    logic             none;
    logic [IW-1:0]    sel_idx;
    logic [RES_W-1:0] elem_data;
    res_t             res_q;

    assign size_e = elem_size_e'(in_size);
    assign mode_e = pick_mode_e'(in_mode);

    vlx_active_map #(.VLEN(VLEN)) u_map (
        .pred (in_pred),
        .size (size_e),
        .act  (act)
    );

    vlx_last_find #(.N(NB)) u_find (
        .act      (act),
        .last_idx (last_idx),
        .none     (none)
    );

    vlx_index_adjust #(.N(NB)) u_adj (
        .last_idx (last_idx),
        .none     (none),
        .size     (size_e),
        .mode     (mode_e),
        .sel_idx  (sel_idx)
    );

    vlx_elem_mux #(.VLEN(VLEN)) u_mux (
        .operand (in_operand),
        .size    (size_e),
        .idx     (sel_idx),
        .data    (elem_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q.vld <= 1'b0;
        end else begin
            res_q.vld <= in_valid;
        end
        if (in_valid) begin
            res_q.data <= elem_data;
        end
    end

    assign out_valid  = res_q.vld;
    assign out_result = res_q.data;
endmodule

// File: rtl/vlx_extract_chk.sv
module vlx_extract_chk
    import vlx_pkg::*;
#(
    parameter int unsigned VLEN = 256,
    localparam int unsigned NB = VLEN / 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        in_size,
    input logic              in_mode,
    input logic [VLEN-1:0]   in_operand,
    input logic [NB-1:0]     in_pred,
    input logic              out_valid,
    input logic [RES_W-1:0]  out_result
);
    p_valid_lat_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drop_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));

    p_zext_b_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'd0) |=> (out_result[63:8] == '0));

    p_zext_h_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'd1) |=> (out_result[63:16] == '0));

    p_zext_w_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'd2) |=> (out_result[63:32] == '0));

    p_none_next_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'd3 && !in_mode && in_pred == '0)
        |=> (out_result == $past(in_operand[63:0])));

    p_none_last_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'd3 && in_mode && in_pred == '0)
        |=> (out_result == $past(in_operand[VLEN-1 -: 64])));
endmodule

bind vlx_extract vlx_extract_chk #(.VLEN(VLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_size    (in_size),
    .in_mode    (in_mode),
    .in_operand (in_operand),
    .in_pred    (in_pred),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/tb_vlx_extract.sv
module tb_vlx_extract;
    localparam int unsigned VLEN = 256;
    localparam int unsigned NB   = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [1:0]      in_size = '0;
    logic            in_mode = 1'b0;
    logic [VLEN-1:0] in_operand = '0;
    logic [NB-1:0]   in_pred = '0;
    logic            out_valid;
    logic [63:0]     out_result;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    vlx_extract #(.VLEN(VLEN)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size),
        .in_mode(in_mode), .in_operand(in_operand), .in_pred(in_pred),
        .out_valid(out_valid), .out_result(out_result)
    );

    // {size[1:0], mode, pred[31:0], expected index[5:0]}
    localparam logic [40:0] TBL [16] = '{
        {2'd0, 1'b0, 32'h0000_0010, 6'd5},
        {2'd0, 1'b1, 32'h0000_0010, 6'd4},
        {2'd0, 1'b0, 32'h8000_0000, 6'd0},
        {2'd0, 1'b0, 32'h0000_0000, 6'd0},
        {2'd0, 1'b1, 32'h0000_0000, 6'd31},
        {2'd1, 1'b0, 32'h0000_0100, 6'd5},
        {2'd1, 1'b0, 32'h0000_0200, 6'd0},
        {2'd1, 1'b1, 32'hAAAA_AAAA, 6'd15},
        {2'd2, 1'b1, 32'h0001_0000, 6'd4},
        {2'd2, 1'b0, 32'h1000_0000, 6'd0},
        {2'd2, 1'b1, 32'h0EEE_EEEE, 6'd7},
        {2'd3, 1'b0, 32'h0000_0101, 6'd2},
        {2'd3, 1'b1, 32'h0100_0000, 6'd3},
        {2'd3, 1'b0, 32'h0100_0000, 6'd0},
        {2'd3, 1'b1, 32'hFEFE_FEFE, 6'd3},
        {2'd3, 1'b0, 32'h0000_0000, 6'd0}
    };

    function automatic logic [VLEN-1:0] make_operand(int seed);
        logic [VLEN-1:0] v;
        for (int k = 0; k < NB; k++) v[k*8 +: 8] = 8'(k * 37 + 11 + seed * 64);
        return v;
    endfunction

    function automatic int model_idx(int sz, bit md, logic [NB-1:0] p);
        int n = NB >> sz;
        int last = -1;
        for (int e = 0; e < n; e++) if (p[e << sz]) last = e;
        if (!md) return (last < 0 || last + 1 >= n) ? 0 : last + 1;
        return (last < 0) ? n - 1 : last;
    endfunction

    function automatic logic [63:0] model_val(logic [VLEN-1:0] op, int sz, int idx);
        logic [63:0] v = '0;
        int eb = 1 << sz;
        for (int b = 0; b < eb; b++) v[b*8 +: 8] = op[(idx * eb + b) * 8 +: 8];
        return v;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Drive one input, then sample at the following falling edge
    task automatic apply(int sz, bit md, logic [NB-1:0] p, logic [VLEN-1:0] op,
                         string req, int exp_idx);
        logic [63:0] exp;
        @(negedge clk);
        in_valid = 1; in_size = 2'(sz); in_mode = md; in_pred = p; in_operand = op;
        @(negedge clk);
        in_valid = 0;
        exp = model_val(op, sz, exp_idx);
        check(out_valid === 1'b1, {req, " valid R8"}, 64'(out_valid), 64'd1);
        check(out_result === exp, req, out_result, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R9 reset", 64'(out_valid), 64'd0);
        rst = 0;

        // Table walk: covers R1 R2 R3 R4 R5 R6 R7
        for (int r = 0; r < 16; r++) begin
            apply(int'(TBL[r][40:39]), TBL[r][38], TBL[r][37:6], make_operand(r),
                  $sformatf("table row %0d R1 R2 R3 R4 R5 R6 R7", r), int'(TBL[r][5:0]));
        end

        // R8: strobe lasts one cycle only
        @(negedge clk);
        check(out_valid === 1'b0, "R8 single pulse", 64'(out_valid), 64'd0);

        // R10: changing inputs without a strobe must not disturb the result
        apply(2, 1, 32'h0000_0100, make_operand(3), "R6 pre-hold", 2);
        held = out_result;
        in_operand = make_operand(9); in_pred = '1; in_size = 2'd0; in_mode = 0;
        repeat (3) @(negedge clk);
        check(out_result === held, "R10 hold", out_result, held);

        // R1: upper bits zero for each narrow size at the top element
        for (int s = 0; s < 3; s++) begin
            apply(s, 1, '0, {VLEN{1'b1}}, "R1 zero-extend", (NB >> s) - 1);
        end

        // Model sweep across sizes and modes, R2 R3 R4 R6
        for (int t = 0; t < 400; t++) begin
            logic [NB-1:0] p = $urandom();
            int sz = t % 4;
            bit md = t[2];
            if (t % 5 == 0) p = p & $urandom() & $urandom();
            if (t % 7 == 0) p[NB - (1 << sz)] = 1'b1;
            apply(sz, md, p, make_operand(t), "sweep R2 R3 R4 R6",
                  model_idx(sz, md, p));
        end

        // R9: reset in the same cycle as a strobe clears valid
        @(negedge clk);
        in_valid = 1; rst = 1;
        @(negedge clk);
        in_valid = 0;
        check(out_valid === 1'b0, "R9 reset over strobe", 64'(out_valid), 64'd0);
        rst = 0;
        @(negedge clk);
        check(out_valid === 1'b0, "R9 idle after reset", 64'(out_valid), 64'd0);

        finish_run();
    end
endmodule